// File: doc/BRIEF.md
# ADC Channel-Sequence FIFO Controller

This block runs a list of analog conversions that software queues in advance. Software pushes 5-bit channel numbers into an eight-entry channel queue. Once the queue holds enough entries for one sequence, the controller sends the channels one at a time to an external converter through a start/channel/done/result handshake. Each 12-bit result goes into an eight-entry result queue, and software pops the results back out in order.

A programmed depth sets how many queued channels make one sequence. Three trigger modes control pacing:

- **Software mode:** the sequence starts as soon as the queue holds enough channels, and it runs back to back.
- **Single hardware trigger mode:** each conversion waits for its own rising edge on the trigger input.
- **Multiple hardware trigger mode:** one rising edge runs the whole sequence.

When the last conversion of the sequence returns its result, a completion flag is set. An interrupt line follows that flag while the interrupt is enabled.

Top module: `adc_seq_fifo`

## Requirements
- R1: After reset, `coco`, `irq`, `conv_start`, `res_level` and `res_data` are all 0.
- R2: The channel queue holds 8 entries of 5 bits. A push while it holds 8 is ignored, and the entries already held are kept unchanged.
- R3: A sequence starts only when the channel queue holds at least the effective depth. The effective depth is 1 when `depth_cfg` is 0, 8 when `depth_cfg` is above 8, and `depth_cfg` otherwise.
- R4: With `hw_trig_en`=0, the first `conv_start` comes in the cycle after the queue reaches the depth. Each later `conv_start` comes in the cycle after the previous `conv_done`. `conv_start` is a one-cycle pulse, and `conv_ch` carries the oldest queued channel.
- R5: With `hw_trig_en`=1 and `multi_trig_en`=0, every conversion of the sequence waits for a new rising edge of `hw_trig`. That edge must be sampled while the controller is waiting, and `conv_start` follows one cycle later.
- R6: With `hw_trig_en`=1 and `multi_trig_en`=1, a single rising edge of `hw_trig` runs every conversion of the sequence back to back.
- R7: `coco` is set in the cycle after `conv_done` of the last conversion of the sequence. `irq` equals `coco` AND `int_en`.
- R8: `coco` clears after a channel push, or after a pop that empties the result queue.
- R9: A rising edge of `hw_trig` that arrives while a conversion is in flight has no effect.
- R10: `res_data` shows the oldest stored result, and `res_pop` removes it. When the result queue is empty, `res_data` is 0 and a pop leaves `res_level` at 0.
- R11: The result queue holds 8 entries of 12 bits. A result that arrives while it is full is dropped, and the stored results are kept.
- R12: `fifo_clr` empties both queues, stops any sequence in progress, and clears `coco`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous clear of both queues and the sequencer |
| hw_trig_en | input | 1 | 1 selects hardware trigger pacing |
| multi_trig_en | input | 1 | With hardware pacing, 1 lets one edge run the whole sequence |
| int_en | input | 1 | Interrupt enable |
| depth_cfg | input | 4 | Programmed sequence length |
| ch_push | input | 1 | Push strobe for the channel queue |
| ch_data | input | 5 | Channel number to push |
| res_pop | input | 1 | Pop strobe for the result queue |
| res_data | output | 12 | Oldest result, or 0 when empty |
| res_level | output | 4 | Number of stored results |
| hw_trig | input | 1 | Hardware trigger, acted on at its rising edge |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_ch | output | 5 | Channel for the requested conversion |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| coco | output | 1 | Sequence complete flag |
| irq | output | 1 | Interrupt request |

## Verification
Every result of this block arrives a fixed number of cycles after its cause:

- `conv_start` shows one cycle after the channel queue reaches the depth (software mode), one cycle after a sampled trigger edge, or one cycle after `conv_done` inside a paced sequence.
- `coco` follows the last `conv_done` by one cycle.
- A pop updates `res_data` and `res_level` one cycle later.

The bench drives every input on the falling edge and samples on the following falling edges, so each check sees the value one full register stage after its stimulus. In single-trigger mode the bench waits for the converter's done strobe plus two cycles before pulsing the trigger. In software mode it measures the gap between each done strobe and the next start, and that gap is expected to be exactly one cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WAIT  = 2'd1,
    SQ_START = 2'd2,
    SQ_CONV  = 2'd3
  } seq_state_e;

  // Depth actually used for a sequence: zero means one, saturate at the queue size.
  function automatic int unsigned eff_depth(int unsigned cfg, int unsigned maxd);
    if (cfg == 0) return 1;
    if (cfg > maxd) return maxd;
    return cfg;
  endfunction

  // Circular pointer step for any queue size.
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/adc_seq_buf.sv
module adc_seq_buf #(
  parameter int W     = 5,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  import adc_seq_pkg::*;

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= AW'(ptr_next(32'(wp), DEPTH));
      if (do_pop)  rp <= AW'(ptr_next(32'(rp), DEPTH));
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wp] <= wdata;
  end

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic trig_edge
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  assign trig_edge = trig_in && !trig_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hw_mode,
  input  logic          multi_mode,
  input  logic [LW-1:0] need,
  input  logic [LW-1:0] ch_level,
  input  logic          trig_edge,
  input  logic          conv_done,
  output logic          conv_start,
  output logic          ch_pop,
  output logic          res_push,
  output logic          seq_done,
  output logic          in_wait,
  output logic          last_conv,
  output logic          busy
);
  import adc_seq_pkg::*;

  seq_state_e    state;
  logic [LW-1:0] remain;
  logic          armed;

  assign armed      = (ch_level >= need);
  assign conv_start = (state == SQ_START);
  assign ch_pop     = conv_start;
  assign res_push   = (state == SQ_CONV) && conv_done;
  assign last_conv  = (remain == LW'(1));
  assign seq_done   = res_push && last_conv;
  assign in_wait    = (state == SQ_WAIT);
  assign busy       = (state == SQ_START) || (state == SQ_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      remain <= '0;
    end else if (clr) begin
      state  <= SQ_IDLE;
      remain <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (armed) begin
          remain <= need;
          state  <= hw_mode ? SQ_WAIT : SQ_START;
        end
        SQ_WAIT:  if (trig_edge) state <= SQ_START;
        SQ_START: state <= SQ_CONV;
        SQ_CONV:  if (conv_done) begin
          remain <= remain - LW'(1);
          if (last_conv)                 state <= SQ_IDLE;
          else if (hw_mode && !multi_mode) state <= SQ_WAIT;
          else                           state <= SQ_START;
        end
        default:  state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int CH_DEPTH = 8,
  parameter int CH_W     = 5,
  parameter int RES_W    = 12,
  localparam int LW      = $clog2(CH_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_clr,
  input  logic             hw_trig_en,
  input  logic             multi_trig_en,
  input  logic             int_en,
  input  logic [LW-1:0]    depth_cfg,
  input  logic             ch_push,
  input  logic [CH_W-1:0]  ch_data,
  input  logic             res_pop,
  output logic [RES_W-1:0] res_data,
  output logic [LW-1:0]    res_level,
  input  logic             hw_trig,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic             coco,
  output logic             irq
);
  import adc_seq_pkg::*;

  logic [LW-1:0]    need;
  logic [LW-1:0]    ch_level;
  logic             ch_full, ch_empty, ch_pop;
  logic             res_full, res_empty, res_push;
  logic [RES_W-1:0] res_head;
  logic             trig_edge, seq_done, in_wait, last_conv, busy;

  assign need = LW'(eff_depth(32'(depth_cfg), CH_DEPTH));

  adc_seq_buf #(.W(CH_W), .DEPTH(CH_DEPTH)) u_ch_q (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(ch_push), .wdata(ch_data), .pop(ch_pop),
    .rdata(conv_ch), .level(ch_level), .full(ch_full), .empty(ch_empty)
  );

  adc_seq_buf #(.W(RES_W), .DEPTH(CH_DEPTH)) u_res_q (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(res_push), .wdata(conv_result), .pop(res_pop),
    .rdata(res_head), .level(res_level), .full(res_full), .empty(res_empty)
  );

  adc_seq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(hw_trig), .trig_edge(trig_edge)
  );

  adc_seq_ctrl #(.LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .hw_mode(hw_trig_en), .multi_mode(multi_trig_en),
    .need(need), .ch_level(ch_level), .trig_edge(trig_edge),
    .conv_done(conv_done), .conv_start(conv_start), .ch_pop(ch_pop),
    .res_push(res_push), .seq_done(seq_done), .in_wait(in_wait),
    .last_conv(last_conv), .busy(busy)
  );

  assign res_data = res_empty ? '0 : res_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        coco <= 1'b0;
    else if (fifo_clr) coco <= 1'b0;
    else if (seq_done) coco <= 1'b1;
    else if (ch_push || (res_pop && res_level == LW'(1))) coco <= 1'b0;
  end

  assign irq = coco && int_en;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          hw_trig_en,
  input logic          multi_trig_en,
  input logic          conv_start,
  input logic          coco,
  input logic          res_pop,
  input logic [LW-1:0] res_level,
  input logic          ch_push,
  input logic [LW-1:0] ch_level,
  input logic          ch_full,
  input logic          ch_pop,
  input logic          in_wait,
  input logic          trig_edge,
  input logic          last_conv,
  input logic          busy,
  input logic          res_push
);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    conv_start |=> !conv_start);

  // R4
  sw_chain_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    res_push && !last_conv && !hw_trig_en |=> conv_start);

  // R6
  multi_chain_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    res_push && !last_conv && hw_trig_en && multi_trig_en |=> conv_start);

  // R5
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    res_push && !last_conv && hw_trig_en && !multi_trig_en |=> !conv_start);

  // R5
  wait_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    in_wait && !trig_edge |=> !conv_start);

  // R9
  busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    busy && trig_edge && !res_push |=> !in_wait);

  // R2
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    ch_push && ch_full && !ch_pop |=> ch_level == $past(ch_level));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n || fifo_clr)
    res_pop && res_level == '0 && !res_push |=> res_level == '0);

  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coco) |-> $past(res_push && last_conv));

endmodule

bind adc_seq_fifo adc_seq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr),
  .hw_trig_en(hw_trig_en), .multi_trig_en(multi_trig_en),
  .conv_start(conv_start), .coco(coco), .res_pop(res_pop),
  .res_level(res_level), .ch_push(ch_push), .ch_level(ch_level),
  .ch_full(ch_full), .ch_pop(ch_pop), .in_wait(in_wait),
  .trig_edge(trig_edge), .last_conv(last_conv), .busy(busy),
  .res_push(res_push)
);

// File: tb/adc_seq_fifo_tb.sv
`timescale 1ns/1ps
module adc_seq_fifo_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_clr = 1'b0, hw_trig_en = 1'b0, multi_trig_en = 1'b0, int_en = 1'b0;
  logic [3:0]  depth_cfg = 4'd1;
  logic        ch_push = 1'b0, res_pop = 1'b0, hw_trig = 1'b0, conv_done;
  logic [4:0]  ch_data = '0;
  logic [11:0] conv_result;
  logic [11:0] res_data;
  logic [3:0]  res_level;
  logic        conv_start, coco, irq;
  logic [4:0]  conv_ch;

  int errors = 0, checks = 0;
  int starts = 0, dones = 0, rcount = 0, cyc = 0;
  int lat_fix = 0, gap_max = 0, last_done = 0;
  bit have_prev = 0;
  logic [4:0]  got_ch[$];
  logic [11:0] exp_res[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .hw_trig_en(hw_trig_en),
    .multi_trig_en(multi_trig_en), .int_en(int_en), .depth_cfg(depth_cfg),
    .ch_push(ch_push), .ch_data(ch_data), .res_pop(res_pop), .res_data(res_data),
    .res_level(res_level), .hw_trig(hw_trig), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_done(conv_done), .conv_result(conv_result),
    .coco(coco), .irq(irq)
  );

  function automatic int eff_d(int cfg);
    if (cfg == 0) return 1;
    return (cfg > 8) ? 8 : cfg;
  endfunction

  function automatic logic [11:0] conv_val(logic [4:0] ch, int n);
    return 12'((int'(ch) * 151 + n * 37 + 5) % 4096);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // converter model
  initial begin
    int g;
    int lat;
    logic [4:0] sch;
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(negedge clk);
      while (conv_start === 1'b1) begin
        starts++;
        sch = conv_ch;
        got_ch.push_back(sch);
        if (have_prev) begin
          g = cyc - last_done;
          if (g > gap_max) gap_max = g;
        end
        lat = (lat_fix > 0) ? lat_fix : int'($urandom_range(1, 4));
        repeat (lat) @(negedge clk);
        conv_result = conv_val(sch, rcount);
        exp_res.push_back(conv_result);
        rcount++;
        conv_done = 1'b1;
        dones++;
        have_prev = 1'b1;
        last_done = cyc;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic push_ch(logic [4:0] c);
    ch_data = c; ch_push = 1'b1;
    @(negedge clk);
    ch_push = 1'b0;
  endtask

  task automatic pulse_trig();
    hw_trig = 1'b1;
    @(negedge clk);
    hw_trig = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_check(string req);
    logic [11:0] e;
    e = (exp_res.size() > 0) ? exp_res.pop_front() : 12'd0;
    chk(res_data == e, req, "result data", int'(res_data), int'(e));
    res_pop = 1'b1;
    @(negedge clk);
    res_pop = 1'b0;
  endtask

  task automatic wait_coco();
    for (int t = 0; t < 3000 && !coco; t++) @(negedge clk);
  endtask

  task automatic wait_dones(int n);
    for (int t = 0; t < 3000 && dones < n; t++) @(negedge clk);
  endtask

  task automatic fresh();
    starts = 0; dones = 0; got_ch.delete(); have_prev = 0; gap_max = 0;
  endtask

  task automatic check_order(string req, logic [4:0] want[$]);
    chk(got_ch.size() == want.size(), req, "start count", got_ch.size(), want.size());
    for (int i = 0; i < want.size() && i < got_ch.size(); i++)
      chk(got_ch[i] == want[i], req, "channel order", int'(got_ch[i]), int'(want[i]));
  endtask

  initial begin
    logic [4:0] want[$];
    int mode, cfg, d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(coco == 0 && irq == 0, "R1", "flags in reset", int'({coco, irq}), 0);
    chk(conv_start == 0, "R1", "start in reset", int'(conv_start), 0);
    chk(res_level == 0 && res_data == 0, "R1", "results in reset", int'(res_level), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 empty pop
    res_pop = 1'b1; @(negedge clk); res_pop = 1'b0;
    chk(res_data == 0, "R10", "empty data", int'(res_data), 0);
    chk(res_level == 0, "R10", "empty pop level", int'(res_level), 0);

    // R3 depth threshold, software mode
    fresh(); depth_cfg = 4'd3;
    push_ch(5'd4); push_ch(5'd9);
    repeat (6) @(negedge clk);
    chk(starts == 0, "R3", "starts below depth", starts, 0);
    push_ch(5'd17);
    wait_coco();
    want = '{5'd4, 5'd9, 5'd17};
    check_order("R3", want);
    for (int i = 0; i < 3; i++) pop_check("R10");

    // R4 back-to-back software sequence
    fresh(); lat_fix = 3; depth_cfg = 4'd4; int_en = 1'b1;
    push_ch(5'd1); push_ch(5'd2); push_ch(5'd3); push_ch(5'd31);
    wait_coco();
    chk(gap_max == 1, "R4", "done to next start gap", gap_max, 1);
    want = '{5'd1, 5'd2, 5'd3, 5'd31};
    check_order("R4", want);
    chk(coco == 1, "R7", "flag after sequence", int'(coco), 1);
    chk(irq == 1, "R7", "irq enabled", int'(irq), 1);
    int_en = 1'b0; @(negedge clk);
    chk(irq == 0, "R7", "irq disabled", int'(irq), 0);
    // R8 push clears flag (depth 2, one push does not start)
    depth_cfg = 4'd2; push_ch(5'd7);
    chk(coco == 0, "R8", "flag after push", int'(coco), 0);
    for (int i = 0; i < 4; i++) pop_check("R10");
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    lat_fix = 0;

    // R3 depth 0 acts as 1, depth 15 acts as 8
    fresh(); depth_cfg = 4'd0;
    push_ch(5'd12);
    wait_coco(); repeat (3) @(negedge clk);
    chk(starts == 1, "R3", "depth zero", starts, 1);
    pop_check("R8");
    chk(coco == 0, "R8", "flag after draining pop", int'(coco), 0);
    fresh(); depth_cfg = 4'd15;
    for (int i = 0; i < 8; i++) push_ch(5'(i + 10));
    wait_coco();
    chk(starts == 8, "R3", "depth saturates", starts, 8);
    for (int i = 0; i < 8; i++) pop_check("R3");

    // R5 and R9 single hardware trigger
    fresh(); hw_trig_en = 1'b1; multi_trig_en = 1'b0; depth_cfg = 4'd3; lat_fix = 8;
    push_ch(5'd5); push_ch(5'd6); push_ch(5'd8);
    repeat (4) @(negedge clk);
    chk(starts == 0, "R5", "no start before trigger", starts, 0);
    pulse_trig();
    wait_dones(1); repeat (6) @(negedge clk);
    chk(starts == 1, "R5", "one start per trigger", starts, 1);
    pulse_trig();
    for (int t = 0; t < 50 && starts < 2; t++) @(negedge clk);
    pulse_trig(); // during conversion
    wait_dones(2); repeat (6) @(negedge clk);
    chk(starts == 2, "R9", "trigger while busy ignored", starts, 2);
    pulse_trig();
    wait_coco();
    want = '{5'd5, 5'd6, 5'd8};
    check_order("R5", want);
    for (int i = 0; i < 3; i++) pop_check("R5");
    lat_fix = 0;

    // R2 and R6: full channel queue, single trigger runs whole sequence
    fresh(); multi_trig_en = 1'b1; depth_cfg = 4'd8;
    for (int i = 0; i < 9; i++) push_ch(5'(i + 1));
    repeat (4) @(negedge clk);
    chk(starts == 0, "R6", "no start before trigger", starts, 0);
    pulse_trig();
    wait_coco(); repeat (10) @(negedge clk);
    want.delete();
    for (int i = 0; i < 8; i++) want.push_back(5'(i + 1));
    check_order("R2", want);
    chk(starts == 8, "R6", "whole sequence on one trigger", starts, 8);
    for (int i = 0; i < 8; i++) pop_check("R6");

    // R11 full result queue drops further results
    fresh(); hw_trig_en = 1'b0; multi_trig_en = 1'b0; depth_cfg = 4'd8;
    for (int i = 0; i < 8; i++) push_ch(5'(i + 20));
    wait_coco();
    for (int i = 0; i < 8; i++) push_ch(5'(i));
    wait_dones(16); wait_coco();
    chk(res_level == 8, "R11", "level when full", int'(res_level), 8);
    for (int i = 0; i < 8; i++) pop_check("R11");
    exp_res.delete();
    chk(res_level == 0, "R11", "drained level", int'(res_level), 0);

    // R12 clear
    fresh(); depth_cfg = 4'd4;
    push_ch(5'd2); push_ch(5'd3);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    push_ch(5'd20); push_ch(5'd21);
    repeat (6) @(negedge clk);
    chk(starts == 0, "R12", "cleared entries gone", starts, 0);
    push_ch(5'd22); push_ch(5'd23);
    wait_coco();
    want = '{5'd20, 5'd21, 5'd22, 5'd23};
    check_order("R12", want);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    exp_res.delete();
    chk(coco == 0 && res_level == 0, "R12", "flag and results cleared", int'(res_level), 0);

    // random sequences
    for (int k = 0; k < 24; k++) begin
      fresh();
      mode = int'($urandom_range(0, 2));
      cfg = int'($urandom_range(0, 15));
      d = eff_d(cfg);
      depth_cfg = 4'(cfg);
      hw_trig_en = (mode != 0);
      multi_trig_en = (mode == 2);
      int_en = 1'($urandom_range(0, 1));
      want.delete();
      for (int i = 0; i < d; i++) begin
        want.push_back(5'($urandom_range(0, 31)));
        push_ch(want[i]);
      end
      repeat (3) @(negedge clk);
      if (mode == 2) pulse_trig();
      else if (mode == 1) begin
        for (int i = 0; i < d; i++) begin
          pulse_trig();
          wait_dones(i + 1);
          repeat (2) @(negedge clk);
        end
      end
      wait_coco();
      chk(coco == 1, "R7", "random flag", int'(coco), 1);
      chk(irq == int_en, "R7", "random irq", int'(irq), int'(int_en));
      check_order(mode == 0 ? "R4" : (mode == 1 ? "R5" : "R6"), want);
      for (int i = 0; i < d; i++) pop_check("R10");
      chk(coco == 0, "R8", "random flag after drain", int'(coco), 0);
      chk(res_level == 0, "R10", "random drained", int'(res_level), 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule